// File: doc/BRIEF.md
# Serial Controller Register Sequencer

This block is the processor-side control path of a programmable serial port that works in either a clocked (synchronous) or a start/stop (asynchronous) framing. It watches an 8-bit bus with an active-low select, active-low read and write strobes, and a line that chooses between the data path and the control path. The shift registers and the bit-rate generator sit outside. This block only hands them the stored setup, the transmit byte with a load pulse, and a take pulse for the received byte.

A control write has no fixed target. Its meaning comes from where it falls in the sequence that starts at reset. The first control write sets the framing setup. In synchronous framing, up to two sync patterns follow, and the setup itself says how many. Every later control write is a command. A command can also send the sequence back to its start. A control read returns a status byte. That byte combines sticky error and sync/break flags with the ready indications from the shift units and the modem inputs.

Top module: `serial_ctl_regs`

## Requirements
- R1: After reset, every command output is inactive (rts_n=1, dtr_n=1, tx_go=0, rx_en=0, send_brk=0, hunt=0). The setup register holds 0, and the first control write (cd_sel=1) is stored in mode_word.
- R2: When mode_word[1:0] is non-zero (asynchronous), the next control write is a command. In that case clk_div is 1, 16 or 64 for the values 01, 10 and 11. When mode_word[1:0] is 00 (synchronous), clk_div is 1. In every mode, char_bits = 5 + mode_word[3:2].
- R3: In synchronous setup, the number of sync patterns that follow the setup write depends on two bits. If mode_word[6]=1, none follow. Otherwise, if mode_word[7]=1, one follows, and if mode_word[7]=0, two follow. The first lands in sync_char1 and the second in sync_char2. The control write after the last sync pattern is a command.
- R4: A data write (cd_sel=0) puts din on tx_data and pulses tx_load high for exactly one cycle. It leaves the setup and the command outputs unchanged. A data read drives rx_data_i onto dout and holds rx_take high during the access.
- R5: A control read returns the status byte. Its bits are: bit0 transmit-ready (tx_buf_free and command transmit enable and cts_n low), bit1 rx_rdy, bit2 tx_empty, bit3 parity error, bit4 overrun, bit5 framing error, bit6 sync/break detected, and bit7 the inverse of dsr_n.
- R6: Each command write sets the command outputs from its bits. Bit0 is the transmit enable, and tx_go is that enable while cts_n is low. Bit1 sets dtr_n low, bit2 sets rx_en, bit3 sets send_brk, bit5 sets rts_n low, and bit7 sets hunt.
- R7: A one-cycle pulse on par_err_set, ovr_err_set or frm_err_set sets a sticky flag. The flag holds until a command with bit4 set clears it.
- R8: A pulse on syn_brk_set sets status bit6. Reading the status byte clears it. If a set and a read happen in the same cycle, the set wins.
- R9: A command with bit6 set makes every command output inactive. The next control write is then taken as a new setup.
- R10: A strobe is ignored while cs_n is high. A strobe held low over several cycles counts as one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| cd_sel | input | 1 | 1 = control/status, 0 = data |
| din | input | 8 | Write data |
| dout | output | 8 | Read data (status or received byte) |
| rx_data_i | input | 8 | Received byte from the receive shifter |
| rx_take | output | 1 | High during a data read |
| tx_data | output | 8 | Transmit byte to the transmit shifter |
| tx_load | output | 1 | One-cycle pulse after a data write |
| tx_buf_free | input | 1 | Transmit buffer can take a byte |
| tx_empty | input | 1 | Transmitter has nothing left to send |
| rx_rdy | input | 1 | Received byte waiting |
| par_err_set | input | 1 | Parity error pulse |
| ovr_err_set | input | 1 | Overrun pulse |
| frm_err_set | input | 1 | Framing error pulse |
| syn_brk_set | input | 1 | Sync match or break seen pulse |
| cts_n | input | 1 | Active-low clear-to-send |
| dsr_n | input | 1 | Active-low data-set-ready |
| mode_word | output | 8 | Stored setup byte |
| sync_char1 | output | 8 | First sync pattern |
| sync_char2 | output | 8 | Second sync pattern |
| clk_div | output | 7 | Serial clock cycles per bit |
| char_bits | output | 4 | Data bits per character |
| tx_go | output | 1 | Transmit enabled and clear to send |
| rx_en | output | 1 | Receive enable |
| send_brk | output | 1 | Hold the line in break |
| hunt | output | 1 | Search for sync |
| dtr_n | output | 1 | Active-low data-terminal-ready |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
The properties assume a well-behaved bus. Read and write strobes are never low together, and din and cd_sel stay steady for as long as a strobe is low. The status pulse inputs each last one cycle. The stimulus drives every access from the falling clock edge, keeps every field fixed for the whole strobe, and raises only one error or sync pulse at a time relative to any status read. The one exception is the held-strobe case, which is long on purpose so the single-access rule gets tested.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_SYNC1 = 2'd1,
    PH_SYNC2 = 2'd2,
    PH_CMD   = 2'd3
  } phase_t;

  // command bit positions
  localparam int C_TXEN  = 0;
  localparam int C_DTR   = 1;
  localparam int C_RXEN  = 2;
  localparam int C_BRK   = 3;
  localparam int C_ECLR  = 4;
  localparam int C_RTS   = 5;
  localparam int C_IRST  = 6;
  localparam int C_HUNT  = 7;

  // setup field positions
  localparam int M_EXTS  = 6;
  localparam int M_SGL   = 7;

  function automatic logic [1:0] sync_cnt(input logic [1:0] fac, input logic ext, input logic sgl);
    if (fac != 2'b00) return 2'd0;
    if (ext)          return 2'd0;
    if (sgl)          return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [6:0] div_of(input logic [1:0] fac);
    case (fac)
      2'b10:   return 7'd16;
      2'b11:   return 7'd64;
      default: return 7'd1;
    endcase
  endfunction

  function automatic logic [3:0] bits_of(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction
endpackage

// File: rtl/sc_bus_port.sv
module sc_bus_port (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic cd_sel,
  output logic wr_ctl,
  output logic wr_dat,
  output logic rd_ctl,
  output logic rd_dat,
  output logic rd_ctl_lvl
);
  logic wr_act, rd_act;
  logic wr_q, rd_q;
  logic wr_ev, rd_ev;

  assign wr_act = !cs_n && !wr_n;
  assign rd_act = !cs_n && !rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end
  end

  // one event per strobe, on its leading cycle
  assign wr_ev      = wr_act && !wr_q;
  assign rd_ev      = rd_act && !rd_q;
  assign wr_ctl     = wr_ev && cd_sel;
  assign wr_dat     = wr_ev && !cd_sel;
  assign rd_ctl     = rd_ev && cd_sel;
  assign rd_dat     = rd_act && !cd_sel;
  assign rd_ctl_lvl = rd_act && cd_sel;
endmodule

// File: rtl/sc_ctrl_seq.sv
module sc_ctrl_seq
  import sc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic [DW-1:0] din,
  output phase_t        phase,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] sync1_q,
  output logic [DW-1:0] sync2_q,
  output logic          cmd_tx,
  output logic          cmd_dtr,
  output logic          cmd_rx,
  output logic          cmd_brk,
  output logic          cmd_rts,
  output logic          cmd_hunt,
  output logic          err_clr
);
  phase_t     phase_d;
  logic       mode_en, s1_en, s2_en, cmd_en, cmd_clr;
  logic [1:0] cnt_new, cnt_cur;

  assign cnt_new = sync_cnt(din[1:0], din[M_EXTS], din[M_SGL]);
  assign cnt_cur = sync_cnt(mode_q[1:0], mode_q[M_EXTS], mode_q[M_SGL]);

  always_comb begin
    phase_d = phase;
    mode_en = 1'b0;
    s1_en   = 1'b0;
    s2_en   = 1'b0;
    cmd_en  = 1'b0;
    cmd_clr = 1'b0;
    err_clr = 1'b0;
    if (wr_ctl) begin
      case (phase)
        PH_SETUP: begin
          mode_en = 1'b1;
          phase_d = (cnt_new == 2'd0) ? PH_CMD : PH_SYNC1;
        end
        PH_SYNC1: begin
          s1_en   = 1'b1;
          phase_d = (cnt_cur == 2'd2) ? PH_SYNC2 : PH_CMD;
        end
        PH_SYNC2: begin
          s2_en   = 1'b1;
          phase_d = PH_CMD;
        end
        default: begin
          if (din[C_IRST]) begin
            cmd_clr = 1'b1;
            phase_d = PH_SETUP;
          end else begin
            cmd_en  = 1'b1;
            err_clr = din[C_ECLR];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_SETUP;
    else        phase <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sync1_q <= '0;
    else if (s1_en) sync1_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sync2_q <= '0;
    else if (s2_en) sync2_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_tx <= 1'b0; cmd_dtr <= 1'b0; cmd_rx <= 1'b0;
      cmd_brk <= 1'b0; cmd_rts <= 1'b0; cmd_hunt <= 1'b0;
    end else if (cmd_clr) begin
      cmd_tx <= 1'b0; cmd_dtr <= 1'b0; cmd_rx <= 1'b0;
      cmd_brk <= 1'b0; cmd_rts <= 1'b0; cmd_hunt <= 1'b0;
    end else if (cmd_en) begin
      cmd_tx   <= din[C_TXEN];
      cmd_dtr  <= din[C_DTR];
      cmd_rx   <= din[C_RXEN];
      cmd_brk  <= din[C_BRK];
      cmd_rts  <= din[C_RTS];
      cmd_hunt <= din[C_HUNT];
    end
  end
endmodule

// File: rtl/sc_status.sv
module sc_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          par_set,
  input  logic          ovr_set,
  input  logic          frm_set,
  input  logic          syn_set,
  input  logic          err_clr,
  input  logic          rd_clr,
  input  logic          tx_buf_free,
  input  logic          rx_rdy,
  input  logic          tx_empty,
  input  logic          tx_en,
  input  logic          cts_n,
  input  logic          dsr_n,
  output logic          par_f,
  output logic          ovr_f,
  output logic          frm_f,
  output logic          syn_f,
  output logic [DW-1:0] status
);
  logic par_d, ovr_d, frm_d, syn_d;

  always_comb begin
    par_d = par_set || (par_f && !err_clr);
    ovr_d = ovr_set || (ovr_f && !err_clr);
    frm_d = frm_set || (frm_f && !err_clr);
    syn_d = syn_set || (syn_f && !rd_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_f <= 1'b0; ovr_f <= 1'b0; frm_f <= 1'b0; syn_f <= 1'b0;
    end else begin
      par_f <= par_d; ovr_f <= ovr_d; frm_f <= frm_d; syn_f <= syn_d;
    end
  end

  always_comb begin
    status    = '0;
    status[0] = tx_buf_free && tx_en && !cts_n;
    status[1] = rx_rdy;
    status[2] = tx_empty;
    status[3] = par_f;
    status[4] = ovr_f;
    status[5] = frm_f;
    status[6] = syn_f;
    status[7] = !dsr_n;
  end
endmodule

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs
  import sc_pkg::*;
#(
  parameter int DW         = 8,
  parameter int DIV_W      = 7,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          cd_sel,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic [DW-1:0] rx_data_i,
  output logic          rx_take,
  output logic [DW-1:0] tx_data,
  output logic          tx_load,
  input  logic          tx_buf_free,
  input  logic          tx_empty,
  input  logic          rx_rdy,
  input  logic          par_err_set,
  input  logic          ovr_err_set,
  input  logic          frm_err_set,
  input  logic          syn_brk_set,
  input  logic          cts_n,
  input  logic          dsr_n,
  output logic [DW-1:0] mode_word,
  output logic [DW-1:0] sync_char1,
  output logic [DW-1:0] sync_char2,
  output logic [DIV_W-1:0] clk_div,
  output logic [3:0]    char_bits,
  output logic          tx_go,
  output logic          rx_en,
  output logic          send_brk,
  output logic          hunt,
  output logic          dtr_n,
  output logic          rts_n
);
  // reset: asserted asynchronously, released through a short flop chain
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_ok = rst_pipe[RST_STAGES-1];

  logic   wr_ctl, wr_dat, rd_ctl, rd_dat, rd_ctl_lvl;
  phase_t phase;
  logic   cmd_tx, cmd_dtr, cmd_rx, cmd_brk, cmd_rts, cmd_hunt, err_clr;
  logic   par_f, ovr_f, frm_f, syn_f;
  logic [DW-1:0] status;

  sc_bus_port u_bus (
    .clk(clk), .rst_n(rst_ok), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .cd_sel(cd_sel), .wr_ctl(wr_ctl), .wr_dat(wr_dat), .rd_ctl(rd_ctl),
    .rd_dat(rd_dat), .rd_ctl_lvl(rd_ctl_lvl)
  );

  sc_ctrl_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_ok), .wr_ctl(wr_ctl), .din(din), .phase(phase),
    .mode_q(mode_word), .sync1_q(sync_char1), .sync2_q(sync_char2),
    .cmd_tx(cmd_tx), .cmd_dtr(cmd_dtr), .cmd_rx(cmd_rx), .cmd_brk(cmd_brk),
    .cmd_rts(cmd_rts), .cmd_hunt(cmd_hunt), .err_clr(err_clr)
  );

  sc_status #(.DW(DW)) u_stat (
    .clk(clk), .rst_n(rst_ok), .par_set(par_err_set), .ovr_set(ovr_err_set),
    .frm_set(frm_err_set), .syn_set(syn_brk_set), .err_clr(err_clr),
    .rd_clr(rd_ctl), .tx_buf_free(tx_buf_free), .rx_rdy(rx_rdy),
    .tx_empty(tx_empty), .tx_en(cmd_tx), .cts_n(cts_n), .dsr_n(dsr_n),
    .par_f(par_f), .ovr_f(ovr_f), .frm_f(frm_f), .syn_f(syn_f),
    .status(status)
  );

  // transmit holding register and load pulse
  logic tx_load_d;
  assign tx_load_d = wr_dat;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)     tx_data <= '0;
    else if (wr_dat) tx_data <= din;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) tx_load <= 1'b0;
    else         tx_load <= tx_load_d;
  end

  assign dout      = rd_ctl_lvl ? status : rx_data_i;
  assign rx_take   = rd_dat;
  assign clk_div   = div_of(mode_word[1:0]);
  assign char_bits = bits_of(mode_word[3:2]);
  assign tx_go     = cmd_tx && !cts_n;
  assign rx_en     = cmd_rx;
  assign send_brk  = cmd_brk;
  assign hunt      = cmd_hunt;
  assign dtr_n     = !cmd_dtr;
  assign rts_n     = !cmd_rts;
endmodule

// File: rtl/serial_ctl_chk.sv
module serial_ctl_chk
  import sc_pkg::*;
(
  input logic       clk,
  input logic       rst_ok,
  input logic       cs_n,
  input logic [7:0] din,
  input logic       wr_ctl,
  input logic       wr_dat,
  input logic       rd_ctl,
  input phase_t     phase,
  input logic [7:0] mode_word,
  input logic [7:0] sync_char1,
  input logic [7:0] tx_data,
  input logic       tx_load,
  input logic       rts_n,
  input logic       dtr_n,
  input logic       par_f,
  input logic       ovr_f,
  input logic       frm_f,
  input logic       syn_f,
  input logic       par_err_set,
  input logic       ovr_err_set,
  input logic       frm_err_set,
  input logic       syn_brk_set
);
  // R1
  setup_capture_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_ctl && phase == PH_SETUP) |=> (mode_word == $past(din)));

  // R3
  sync_capture_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_ctl && phase == PH_SYNC1) |=> (sync_char1 == $past(din)));

  // R4
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_dat |=> (tx_load && tx_data == $past(din) && $stable(mode_word) && $stable(rts_n)));

  // R6
  rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_ctl && phase == PH_CMD && !din[C_IRST]) |=> (rts_n == !$past(din[C_RTS])));

  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_ctl && phase == PH_CMD && din[C_IRST]) |=> (phase == PH_SETUP && rts_n && dtr_n));

  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_ctl && phase == PH_CMD && !din[C_IRST] && din[C_ECLR] &&
     !par_err_set && !ovr_err_set && !frm_err_set) |=> (!par_f && !ovr_f && !frm_f));

  // R8
  syn_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_ctl && !syn_brk_set) |=> !syn_f);

  // R8
  syn_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    syn_brk_set |=> syn_f);

  // R10
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    cs_n |=> ($stable(mode_word) && $stable(sync_char1) && !tx_load));
endmodule

bind serial_ctl_regs serial_ctl_chk i_chk (
  .clk(clk), .rst_ok(rst_ok), .cs_n(cs_n), .din(din), .wr_ctl(wr_ctl),
  .wr_dat(wr_dat), .rd_ctl(rd_ctl), .phase(phase), .mode_word(mode_word),
  .sync_char1(sync_char1), .tx_data(tx_data), .tx_load(tx_load),
  .rts_n(rts_n), .dtr_n(dtr_n), .par_f(par_f), .ovr_f(ovr_f), .frm_f(frm_f),
  .syn_f(syn_f), .par_err_set(par_err_set), .ovr_err_set(ovr_err_set),
  .frm_err_set(frm_err_set), .syn_brk_set(syn_brk_set)
);

// File: tb/test_serial_ctl_regs.sv
module test_serial_ctl_regs;
  logic clk = 1'b0;
  logic rst_n, cs_n, rd_n, wr_n, cd_sel;
  logic [7:0] din, dout, rx_data_i, tx_data, mode_word, sync_char1, sync_char2;
  logic rx_take, tx_load, tx_buf_free, tx_empty, rx_rdy;
  logic par_err_set, ovr_err_set, frm_err_set, syn_brk_set, cts_n, dsr_n;
  logic [6:0] clk_div;
  logic [3:0] char_bits;
  logic tx_go, rx_en, send_brk, hunt, dtr_n, rts_n;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #4 clk = ~clk;

  serial_ctl_regs i_serial_ctl_regs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .cd_sel(cd_sel), .din(din), .dout(dout), .rx_data_i(rx_data_i),
    .rx_take(rx_take), .tx_data(tx_data), .tx_load(tx_load),
    .tx_buf_free(tx_buf_free), .tx_empty(tx_empty), .rx_rdy(rx_rdy),
    .par_err_set(par_err_set), .ovr_err_set(ovr_err_set),
    .frm_err_set(frm_err_set), .syn_brk_set(syn_brk_set), .cts_n(cts_n),
    .dsr_n(dsr_n), .mode_word(mode_word), .sync_char1(sync_char1),
    .sync_char2(sync_char2), .clk_div(clk_div), .char_bits(char_bits),
    .tx_go(tx_go), .rx_en(rx_en), .send_brk(send_brk), .hunt(hunt),
    .dtr_n(dtr_n), .rts_n(rts_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic cd, input logic [7:0] v, input int hold);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; cd_sel = cd; din = v;
    repeat (hold) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    #1;
  endtask

  task automatic rd(input logic cd, input logic [7:0] exp, input string req);
    exp_q.push_back(exp);
    req_q.push_back(req);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; cd_sel = cd;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    #1;
  endtask

  // scoreboard monitor: compares each read as it appears on dout
  always @(negedge clk) begin
    #2;
    if (!cs_n && !rd_n) begin
      if (exp_q.size() == 0) begin
        chk("unexpected read", 32'd1, 32'd0);
      end else begin
        logic [7:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(r, {24'd0, dout}, {24'd0, e});
        if (!cd_sel) chk("R4 rx_take", {31'd0, rx_take}, 32'd1);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; cd_sel = 1'b1;
    din = 8'h00; rx_data_i = 8'h00; tx_buf_free = 1'b1; tx_empty = 1'b1;
    rx_rdy = 1'b0; par_err_set = 1'b0; ovr_err_set = 1'b0; frm_err_set = 1'b0;
    syn_brk_set = 1'b0; cts_n = 1'b0; dsr_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 rts_n", {31'd0, rts_n}, 32'd1);
    chk("R1 dtr_n", {31'd0, dtr_n}, 32'd1);
    chk("R1 cmd outs", {28'd0, tx_go, rx_en, send_brk, hunt}, 32'd0);
    chk("R1 mode", {24'd0, mode_word}, 32'd0);
    rd(1'b1, 8'h04, "R5 status after reset");

    // R10 deselected write ignored
    @(negedge clk); wr_n = 1'b0; cd_sel = 1'b1; din = 8'h4E;
    @(negedge clk); wr_n = 1'b1; #1;
    chk("R10 deselected", {24'd0, mode_word}, 32'd0);

    // R1/R2 asynchronous setup x16, 8 bits
    wr(1'b1, 8'h4E, 1);
    chk("R1 mode stored", {24'd0, mode_word}, 32'h4E);
    chk("R2 div16", {25'd0, clk_div}, 32'd16);
    chk("R2 char bits", {28'd0, char_bits}, 32'd8);

    // R2/R6 next write is a command
    wr(1'b1, 8'h27, 1);
    chk("R2 mode kept", {24'd0, mode_word}, 32'h4E);
    chk("R6 rts_n", {31'd0, rts_n}, 32'd0);
    chk("R6 dtr_n", {31'd0, dtr_n}, 32'd0);
    chk("R6 rx_en/tx_go", {30'd0, rx_en, tx_go}, 32'd3);
    chk("R6 brk/hunt", {30'd0, send_brk, hunt}, 32'd0);
    cts_n = 1'b1; #1;
    chk("R6 tx_go gated by cts_n", {31'd0, tx_go}, 32'd0);
    rd(1'b1, 8'h04, "R5 txrdy off with cts_n high");
    cts_n = 1'b0; rx_rdy = 1'b1; dsr_n = 1'b0;
    rd(1'b1, 8'h87, "R5 status ready bits");

    // R4 data path
    wr(1'b0, 8'hA5, 1);
    chk("R4 tx_data", {24'd0, tx_data}, 32'hA5);
    chk("R4 tx_load high", {31'd0, tx_load}, 32'd1);
    @(negedge clk); #1;
    chk("R4 tx_load one cycle", {31'd0, tx_load}, 32'd0);
    chk("R4 mode untouched", {24'd0, mode_word}, 32'h4E);
    chk("R4 rts untouched", {31'd0, rts_n}, 32'd0);
    rx_data_i = 8'h3C;
    rd(1'b0, 8'h3C, "R4 data read");

    // R7 sticky errors, cleared by command bit4
    @(negedge clk); par_err_set = 1'b1; ovr_err_set = 1'b1; frm_err_set = 1'b1;
    @(negedge clk); par_err_set = 1'b0; ovr_err_set = 1'b0; frm_err_set = 1'b0;
    repeat (2) @(negedge clk);
    rd(1'b1, 8'hBF, "R7 errors sticky");
    wr(1'b1, 8'h37, 1);
    rd(1'b1, 8'h87, "R7 errors cleared");

    // R8 sync/break flag cleared by status read
    @(negedge clk); syn_brk_set = 1'b1;
    @(negedge clk); syn_brk_set = 1'b0;
    rd(1'b1, 8'hC7, "R8 flag set");
    rd(1'b1, 8'h87, "R8 flag cleared by read");
    // R8 set and read in the same cycle: set wins
    exp_q.push_back(8'h87); req_q.push_back("R8 coincident read");
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; cd_sel = 1'b1; syn_brk_set = 1'b1;
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; syn_brk_set = 1'b0;
    rd(1'b1, 8'hC7, "R8 set wins over read");
    rd(1'b1, 8'h87, "R8 later read clears");

    // R9 back to setup, then R3 two sync patterns
    wr(1'b1, 8'h40, 1);
    chk("R9 rts_n", {31'd0, rts_n}, 32'd1);
    chk("R9 dtr_n", {31'd0, dtr_n}, 32'd1);
    chk("R9 outs off", {30'd0, rx_en, tx_go}, 32'd0);
    wr(1'b1, 8'h0C, 1);
    chk("R9 new setup", {24'd0, mode_word}, 32'h0C);
    chk("R2 sync div1", {25'd0, clk_div}, 32'd1);
    wr(1'b1, 8'h16, 1);
    wr(1'b1, 8'h96, 1);
    wr(1'b1, 8'h20, 1);
    chk("R3 sync1", {24'd0, sync_char1}, 32'h16);
    chk("R3 sync2", {24'd0, sync_char2}, 32'h96);
    chk("R3 command after two", {31'd0, rts_n}, 32'd0);
    chk("R3 mode kept", {24'd0, mode_word}, 32'h0C);

    // R3 single sync pattern
    wr(1'b1, 8'h40, 1);
    wr(1'b1, 8'h8C, 1);
    wr(1'b1, 8'h55, 1);
    wr(1'b1, 8'h02, 1);
    chk("R3 single sync1", {24'd0, sync_char1}, 32'h55);
    chk("R3 single sync2 kept", {24'd0, sync_char2}, 32'h96);
    chk("R3 single cmd dtr", {31'd0, dtr_n}, 32'd0);
    chk("R3 single cmd rts", {31'd0, rts_n}, 32'd1);

    // R3 external sync: none
    wr(1'b1, 8'h40, 1);
    wr(1'b1, 8'h4C, 1);
    wr(1'b1, 8'h01, 1);
    chk("R3 ext cmd tx_go", {31'd0, tx_go}, 32'd1);
    chk("R3 ext sync1 kept", {24'd0, sync_char1}, 32'h55);
    chk("R3 ext mode", {24'd0, mode_word}, 32'h4C);

    // R10 long strobe counts once
    wr(1'b1, 8'h40, 1);
    wr(1'b1, 8'h4D, 3);
    wr(1'b1, 8'h20, 1);
    chk("R10 held strobe mode", {24'd0, mode_word}, 32'h4D);
    chk("R10 held strobe then cmd", {31'd0, rts_n}, 32'd0);
    chk("R2 div1 async", {25'd0, clk_div}, 32'd1);

    // R2 x64, 5 bits
    wr(1'b1, 8'h40, 1);
    wr(1'b1, 8'h03, 1);
    chk("R2 div64", {25'd0, clk_div}, 32'd64);
    chk("R2 char bits 5", {28'd0, char_bits}, 32'd5);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule